// File: doc/BRIEF.md
# Timing Event Frame Generator

This block collects trigger pulses from the subsystems of a linear accelerator and events passed on by an upstream site-wide timing link. It turns them into one serial stream of timing frames. Each frame holds a 16-bit event code and a 32-bit data word, and is sent with a modified Manchester line code. Each local trigger input has a fixed event code. Each input can be enabled or disabled on its own. Relayed events keep the code and data word they arrived with. When several requests wait at once, a fixed-priority arbiter picks the next one to send. A frame starts only on the cycle that follows a detected rising edge of the RF-derived reference.

Everything runs on one line clock, `clk`, and one line cell takes two cycles of it. The block watches the reference input with a watchdog counter. If the reference stops, the block drops the permit status it gives to the machine-protection system. The fault stays latched until it is cleared explicitly. While the fault is active, the block still sends a waiting permit-fall frame. It holds every other event back until the fault is cleared.

Top module: `evt_frame_gen`

## Requirements
- R1: A frame is 50 line cells in this order: a start cell carrying 0, then 48 payload bits sent MSB first (the 16-bit event code, then the 32-bit data word), then one parity bit. The parity bit makes the count of ones over the payload and the parity bit odd.
- R2: Every line cell lasts two `clk` cycles. `line_out` toggles at the start of every cell. A cell carrying 1 also toggles in the middle, and a cell carrying 0 does not. Between frames the line sends 1 cells, so it toggles on every cycle.
- R3: The local trigger inputs map to fixed codes: index 0 permit fall 0x0211, index 1 permit reset 0x0212, index 2 HEP macro-pulse 0x0201, index 3 pulsed-study macro-pulse 0x0202, index 4 CW-study start 0x0203, index 5 variable bunch 0x0204, index 6 rate A 0x0221, index 7 rate B 0x0222. A local frame's data word is the value of `stamp` in the cycle the frame launches.
- R4: A rising edge on `trig_in[i]` while `trig_en[i]` is low is dropped. It produces no frame, even if the enable is raised afterwards.
- R5: Each synchronized rising edge on an enabled trigger input produces exactly one frame. An input held high produces one frame only.
- R6: When several requests wait, they are served in this order: index 0, index 1, indices 2 to 5 in ascending order, the relayed event, then indices 6 and 7.
- R7: A `relay_stb` pulse while `relay_en` is high captures `relay_code` and `relay_data`, and the block re-sends them unchanged in a frame. A strobe while `relay_en` is low produces no frame.
- R8: Outside a fault, a frame launches only on a reference edge. After `ref_in` rises, the start cell's second half (the first cell-half that does not toggle) appears on `line_out` 4 cycles later.
- R9: `permit_ok` falls after 16 consecutive cycles with no detected reference edge. It stays low, even after the reference resumes, until `fault_clr` is pulsed.
- R10: While `permit_ok` is low, a waiting permit-fall request (0x0211) is still sent without waiting for a reference edge. All other waiting requests are held, and they are sent once the fault has been cleared.
- R11: While `rst_n` is low, `line_out` is 0 and `permit_ok` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Line clock; one line cell is two cycles |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig_in | input | 8 | Asynchronous trigger inputs, one per local event |
| trig_en | input | 8 | Enable for each local event |
| relay_stb | input | 1 | One-cycle strobe for an upstream event |
| relay_en | input | 1 | Enable for relayed events |
| relay_code | input | 16 | Code of the relayed event |
| relay_data | input | 32 | Data word of the relayed event |
| stamp | input | 32 | Data word for local events, taken when the frame launches |
| ref_in | input | 1 | RF-derived reference input |
| fault_clr | input | 1 | Pulse that clears a latched reference fault |
| line_out | output | 1 | Modified Manchester serial output |
| permit_ok | output | 1 | High while the reference is healthy; low means the permit is pulled |

## Verification
A trigger passes through two synchronizer flops and one edge register, so it is pending three edges after it rises. After that it waits for the next reference edge, which also takes two synchronizer edges. The start cell's second half therefore appears exactly 4 cycles after `ref_in` rises. The bench checks this gap with a cycle counter read at the falling edge. The bench decodes every frame from `line_out` on falling edges, and each frame-content check runs only after a wait that covers the longest reference wait plus the 100 cycles of one frame. The fault checks sample well before and well after the 16-cycle watchdog window and do not depend on the exact edge where the fault is raised.

// File: rtl/evt_pkg.sv
package evt_pkg;
  localparam int NLOC     = 8;
  localparam int REL_SLOT = 6;
  localparam int NREQ     = NLOC + 1;
  localparam int IDX_W    = 4;
  localparam int CODE_W   = 16;
  localparam int DATA_W   = 32;
  localparam int PAY_W    = CODE_W + DATA_W;

  // fixed code table, indexed by local trigger number
  function automatic logic [CODE_W-1:0] loc_code(input logic [IDX_W-1:0] i);
    case (i)
      4'd0:    loc_code = 16'h0211;
      4'd1:    loc_code = 16'h0212;
      4'd2:    loc_code = 16'h0201;
      4'd3:    loc_code = 16'h0202;
      4'd4:    loc_code = 16'h0203;
      4'd5:    loc_code = 16'h0204;
      4'd6:    loc_code = 16'h0221;
      4'd7:    loc_code = 16'h0222;
      default: loc_code = 16'h0000;
    endcase
  endfunction
endpackage

// File: rtl/evt_trig_sync.sv
module evt_trig_sync #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] din,
  input  logic [N-1:0] en,
  input  logic [N-1:0] clr,
  output logic [N-1:0] pend
);
  for (genvar g = 0; g < N; g++) begin : g_ch
    logic s1_q, s2_q, s3_q, pend_q, pend_d;

    always_comb pend_d = (pend_q & ~clr[g]) | (s2_q & ~s3_q & en[g]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1_q   <= 1'b0;
        s2_q   <= 1'b0;
        s3_q   <= 1'b0;
        pend_q <= 1'b0;
      end else begin
        s1_q   <= din[g];
        s2_q   <= s1_q;
        s3_q   <= s2_q;
        pend_q <= pend_d;
      end
    end

    assign pend[g] = pend_q;
  end
endmodule

// File: rtl/evt_prio_arb.sv
module evt_prio_arb #(
  parameter int N  = 9,
  parameter int IW = 4
) (
  input  logic [N-1:0]  req,
  output logic [N-1:0]  grant,
  output logic [IW-1:0] idx,
  output logic          any
);
  always_comb begin
    grant = '0;
    idx   = '0;
    any   = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (req[i] && !any) begin
        grant[i] = 1'b1;
        idx      = IW'(i);
        any      = 1'b1;
      end
    end
  end
endmodule

// File: rtl/evt_ref_mon.sv
module evt_ref_mon #(
  parameter int WD_LIMIT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_in,
  input  logic fault_clr,
  output logic ref_pulse,
  output logic fault
);
  localparam int CW = $clog2(WD_LIMIT + 1);

  logic          r1_q, r2_q, r3_q;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          fault_q, fault_d;

  assign ref_pulse = r2_q & ~r3_q;
  assign fault     = fault_q;

  always_comb begin
    cnt_d = cnt_q;
    if (fault_clr || ref_pulse)        cnt_d = '0;
    else if (cnt_q != CW'(WD_LIMIT))   cnt_d = cnt_q + CW'(1);
    fault_d = fault_q;
    if (fault_clr)                     fault_d = 1'b0;
    else if (cnt_d == CW'(WD_LIMIT))   fault_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r1_q    <= 1'b0;
      r2_q    <= 1'b0;
      r3_q    <= 1'b0;
      cnt_q   <= '0;
      fault_q <= 1'b0;
    end else begin
      r1_q    <= ref_in;
      r2_q    <= r1_q;
      r3_q    <= r2_q;
      cnt_q   <= cnt_d;
      fault_q <= fault_d;
    end
  end
endmodule

// File: rtl/evt_mm_ser.sv
module evt_mm_ser #(
  parameter int PAY_W = 48
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             launch,
  input  logic [PAY_W-1:0] payload,
  output logic             line,
  output logic             busy
);
  localparam int FR_W = PAY_W + 2;
  localparam int CNW  = $clog2(FR_W);

  logic [FR_W-1:0] sh_q, sh_d;
  logic [CNW-1:0]  cnt_q, cnt_d;
  logic            half_q, half_d, busy_q, busy_d, line_q, line_d;

  always_comb begin
    line_d = line_q;
    busy_d = busy_q;
    half_d = half_q;
    cnt_d  = cnt_q;
    sh_d   = sh_q;
    if (!busy_q) begin
      line_d = ~line_q;
      if (launch) begin
        busy_d = 1'b1;
        half_d = 1'b1;
        cnt_d  = '0;
        sh_d   = {1'b0, payload, ~^payload};
      end
    end else if (!half_q) begin
      line_d = ~line_q;
      half_d = 1'b1;
    end else begin
      if (sh_q[FR_W-1]) line_d = ~line_q;
      sh_d   = sh_q << 1;
      half_d = 1'b0;
      if (cnt_q == CNW'(FR_W - 1)) busy_d = 1'b0;
      else                         cnt_d  = cnt_q + CNW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      cnt_q  <= '0;
      half_q <= 1'b0;
      busy_q <= 1'b0;
      line_q <= 1'b0;
    end else begin
      sh_q   <= sh_d;
      cnt_q  <= cnt_d;
      half_q <= half_d;
      busy_q <= busy_d;
      line_q <= line_d;
    end
  end

  assign line = line_q;
  assign busy = busy_q;
endmodule

// File: rtl/evt_frame_gen.sv
module evt_frame_gen
  import evt_pkg::*;
#(
  parameter int WD_LIMIT = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NLOC-1:0]   trig_in,
  input  logic [NLOC-1:0]   trig_en,
  input  logic              relay_stb,
  input  logic              relay_en,
  input  logic [CODE_W-1:0] relay_code,
  input  logic [DATA_W-1:0] relay_data,
  input  logic [DATA_W-1:0] stamp,
  input  logic              ref_in,
  input  logic              fault_clr,
  output logic              line_out,
  output logic              permit_ok
);
  logic [NLOC-1:0]   loc_pend, loc_clr;
  logic [NREQ-1:0]   req, req_eff, grant_oh, clr_oh;
  logic [IDX_W-1:0]  gidx, lidx;
  logic              grant_any, launch, busy, ref_pulse, fault;
  logic              rel_pend_q, rel_pend_d, rel_take, rel_clr;
  logic [CODE_W-1:0] rel_code_q, rel_code_d, code_sel;
  logic [DATA_W-1:0] rel_data_q, rel_data_d, data_sel;

  evt_trig_sync #(.N(NLOC)) u_trig (
    .clk(clk), .rst_n(rst_n), .din(trig_in), .en(trig_en),
    .clr(loc_clr), .pend(loc_pend)
  );

  evt_ref_mon #(.WD_LIMIT(WD_LIMIT)) u_ref (
    .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .fault_clr(fault_clr),
    .ref_pulse(ref_pulse), .fault(fault)
  );

  // relayed request sits between the bunch events and the rate events
  assign req     = {loc_pend[NLOC-1:REL_SLOT], rel_pend_q, loc_pend[REL_SLOT-1:0]};
  assign req_eff = fault ? (req & NREQ'(1)) : req;

  evt_prio_arb #(.N(NREQ), .IW(IDX_W)) u_arb (
    .req(req_eff), .grant(grant_oh), .idx(gidx), .any(grant_any)
  );

  assign launch  = !busy && grant_any && (fault || ref_pulse);
  assign clr_oh  = launch ? grant_oh : '0;
  assign loc_clr = {clr_oh[NREQ-1:REL_SLOT+1], clr_oh[REL_SLOT-1:0]};
  assign rel_clr = clr_oh[REL_SLOT];

  always_comb begin
    rel_take   = relay_stb && relay_en && (!rel_pend_q || rel_clr);
    rel_pend_d = rel_take || (rel_pend_q && !rel_clr);
    rel_code_d = rel_take ? relay_code : rel_code_q;
    rel_data_d = rel_take ? relay_data : rel_data_q;
    lidx       = (gidx > IDX_W'(REL_SLOT)) ? gidx - IDX_W'(1) : gidx;
    code_sel   = (gidx == IDX_W'(REL_SLOT)) ? rel_code_q : loc_code(lidx);
    data_sel   = (gidx == IDX_W'(REL_SLOT)) ? rel_data_q : stamp;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rel_pend_q <= 1'b0;
      rel_code_q <= '0;
      rel_data_q <= '0;
    end else begin
      rel_pend_q <= rel_pend_d;
      rel_code_q <= rel_code_d;
      rel_data_q <= rel_data_d;
    end
  end

  evt_mm_ser #(.PAY_W(PAY_W)) u_ser (
    .clk(clk), .rst_n(rst_n), .launch(launch),
    .payload({code_sel, data_sel}), .line(line_out), .busy(busy)
  );

  assign permit_ok = ~fault;
endmodule

// File: rtl/evt_frame_gen_chk.sv
module evt_frame_gen_chk #(
  parameter int NR = 9,
  parameter int NL = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          line_out,
  input logic          permit_ok,
  input logic          fault_clr,
  input logic          busy,
  input logic          launch,
  input logic          ref_pulse,
  input logic [NR-1:0] grant_oh,
  input logic [NR-1:0] req,
  input logic [NL-1:0] pend,
  input logic [NL-1:0] trig_en
);
  // R2
  idle_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> (line_out != $past(line_out)));
  // R4
  enable_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend & ~$past(pend) & ~$past(trig_en)) == '0);
  // R6
  prio_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    launch |-> ($onehot(grant_oh) && ((grant_oh & req) != '0)));
  // R8
  ref_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (launch && permit_ok) |-> ref_pulse);
  // R9
  fault_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!permit_ok && !fault_clr) |=> !permit_ok);
  // R10
  fault_only_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (launch && !permit_ok) |-> grant_oh[0]);
endmodule

bind evt_frame_gen evt_frame_gen_chk #(.NR(evt_pkg::NREQ), .NL(evt_pkg::NLOC)) u_chk (
  .clk(clk), .rst_n(rst_n), .line_out(line_out), .permit_ok(permit_ok),
  .fault_clr(fault_clr), .busy(busy), .launch(launch), .ref_pulse(ref_pulse),
  .grant_oh(grant_oh), .req(req_eff), .pend(loc_pend), .trig_en(trig_en)
);

// File: tb/sim_evt_frame_gen.sv
module sim_evt_frame_gen;
  localparam int CLK_PERIOD = 10;

  logic        clk, rst_n;
  logic [7:0]  trig_in, trig_en;
  logic        relay_stb, relay_en, ref_in, fault_clr;
  logic [15:0] relay_code;
  logic [31:0] relay_data, stamp;
  logic        line_out, permit_ok;

  evt_frame_gen u0 (
    .clk(clk), .rst_n(rst_n), .trig_in(trig_in), .trig_en(trig_en),
    .relay_stb(relay_stb), .relay_en(relay_en), .relay_code(relay_code),
    .relay_data(relay_data), .stamp(stamp), .ref_in(ref_in),
    .fault_clr(fault_clr), .line_out(line_out), .permit_ok(permit_ok)
  );

  int checks = 0, failures = 0, cyc = 0, nfr = 0;
  logic ref_run = 1'b0, ref_man = 1'b0, dec_on = 1'b0, done = 1'b0;
  logic [47:0] fr_pay [64];
  logic        fr_par [64];
  logic        fr_bnd [64];
  int          fr_cyc [64];

  // idx[20:17], enable[16], expected code[15:0]
  localparam logic [20:0] VEC [10] = '{
    {4'd0, 1'b1, 16'h0211}, {4'd1, 1'b1, 16'h0212}, {4'd2, 1'b1, 16'h0201},
    {4'd3, 1'b1, 16'h0202}, {4'd4, 1'b1, 16'h0203}, {4'd5, 1'b1, 16'h0204},
    {4'd6, 1'b1, 16'h0221}, {4'd7, 1'b1, 16'h0222}, {4'd2, 1'b0, 16'h0201},
    {4'd5, 1'b0, 16'h0204}
  };

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // reference source: period 8 cycles while running
  initial begin
    int rc = 0;
    ref_in = 1'b0;
    forever begin
      @(negedge clk);
      if (ref_run) begin
        rc++;
        if (rc == 4) begin rc = 0; ref_in = ~ref_in; end
      end else begin
        rc = 0;
        ref_in = ref_man;
      end
    end
  end

  // line decoder
  initial begin
    logic prev, s, a, b, last, ok, pb;
    logic [47:0] p;
    int sc;
    prev = 1'b0;
    forever begin
      @(negedge clk);
      s = line_out;
      if (dec_on && s == prev) begin
        sc = cyc; p = '0; ok = 1'b1; last = s; pb = 1'b0;
        for (int c = 0; c < 49; c++) begin
          @(negedge clk); a = line_out;
          @(negedge clk); b = line_out;
          if (a == last) ok = 1'b0;
          if (c < 48) p = {p[46:0], a != b};
          else        pb = (a != b);
          last = b;
        end
        if (nfr < 64) begin
          fr_pay[nfr] = p; fr_par[nfr] = ^{p, pb}; fr_bnd[nfr] = ok; fr_cyc[nfr] = sc;
        end
        nfr++;
        prev = last;
      end else prev = s;
    end
  end

  task automatic chk(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chk_frame(input int k, input logic [15:0] code, input logic [31:0] data, input string req);
    chk(fr_pay[k][47:32] == code, req, 64'(fr_pay[k][47:32]), 64'(code));
    chk(fr_pay[k][31:0] == data, req, 64'(fr_pay[k][31:0]), 64'(data));
    chk(fr_par[k] == 1'b1, "R1 parity", 64'(fr_par[k]), 64'd1);
    chk(fr_bnd[k] == 1'b1, "R2 boundary", 64'(fr_bnd[k]), 64'd1);
  endtask

  task automatic pulse_trig(input logic [7:0] m, input int len);
    @(negedge clk) trig_in = m;
    repeat (len) @(negedge clk);
    trig_in = '0;
  endtask

  task automatic relay_send(input logic en, input logic [15:0] c, input logic [31:0] d);
    @(negedge clk);
    relay_en = en; relay_code = c; relay_data = d; relay_stb = 1'b1;
    @(negedge clk) relay_stb = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int base;
    logic p0;
    rst_n = 1'b0; trig_in = '0; trig_en = 8'hFF; relay_stb = 1'b0; relay_en = 1'b1;
    relay_code = '0; relay_data = '0; stamp = 32'h0; fault_clr = 1'b0;
    repeat (4) @(negedge clk);
    chk(line_out == 1'b0, "R11 line", 64'(line_out), 64'd0);
    chk(permit_ok == 1'b1, "R11 permit", 64'(permit_ok), 64'd1);
    rst_n = 1'b1; ref_run = 1'b1;
    @(negedge clk) p0 = line_out;
    @(negedge clk);
    chk(line_out != p0, "R2 idle toggle", 64'(line_out), 64'(~p0));
    dec_on = 1'b1;
    repeat (4) @(negedge clk);

    // table: R3 codes, R4 enable drop
    for (int i = 0; i < 10; i++) begin
      base = nfr;
      trig_en = VEC[i][16] ? 8'hFF : ~(8'd1 << VEC[i][20:17]);
      stamp = 32'hC0DE_0000 + 32'(i);
      pulse_trig(8'd1 << VEC[i][20:17], 3);
      repeat (140) @(negedge clk);
      if (VEC[i][16]) begin
        chk(nfr == base + 1, "R3 count", 64'(nfr - base), 64'd1);
        chk_frame(base, VEC[i][15:0], stamp, "R3 code/data");
      end else begin
        chk(nfr == base, "R4 disabled", 64'(nfr - base), 64'd0);
        trig_en = 8'hFF;
        repeat (150) @(negedge clk);
        chk(nfr == base, "R4 late enable", 64'(nfr - base), 64'd0);
      end
    end

    // R6 priority with a relayed event in the middle, R7 relay content
    base = nfr; stamp = 32'h5555_AAAA;
    @(negedge clk) trig_in = 8'hCF;
    @(negedge clk);
    relay_en = 1'b1; relay_code = 16'h000C; relay_data = 32'h1234_5678; relay_stb = 1'b1;
    @(negedge clk) relay_stb = 1'b0;
    @(negedge clk) trig_in = '0;
    repeat (850) @(negedge clk);
    chk(nfr == base + 7, "R6 count", 64'(nfr - base), 64'd7);
    chk_frame(base + 0, 16'h0211, stamp, "R6 order0");
    chk_frame(base + 1, 16'h0212, stamp, "R6 order1");
    chk_frame(base + 2, 16'h0201, stamp, "R6 order2");
    chk_frame(base + 3, 16'h0202, stamp, "R6 order3");
    chk_frame(base + 4, 16'h000C, 32'h1234_5678, "R7 relay in R6 order");
    chk_frame(base + 5, 16'h0221, stamp, "R6 order5");
    chk_frame(base + 6, 16'h0222, stamp, "R6 order6");

    // R7 relay pass and drop
    base = nfr;
    relay_send(1'b1, 16'h008F, 32'hDEAD_BEEF);
    repeat (140) @(negedge clk);
    chk(nfr == base + 1, "R7 count", 64'(nfr - base), 64'd1);
    chk_frame(base, 16'h008F, 32'hDEAD_BEEF, "R7 relay");
    base = nfr;
    relay_send(1'b0, 16'h0000, 32'h0BAD_0BAD);
    repeat (150) @(negedge clk);
    chk(nfr == base, "R7 disabled relay", 64'(nfr - base), 64'd0);

    // R5 held-high trigger gives one frame
    base = nfr;
    pulse_trig(8'h10, 400);
    repeat (150) @(negedge clk);
    chk(nfr == base + 1, "R5 one frame", 64'(nfr - base), 64'd1);

    // R8 launch 4 cycles after reference rise
    begin
      int rise_cyc;
      base = nfr;
      @(posedge ref_in);
      @(posedge clk);
      ref_man = 1'b0; ref_run = 1'b0;
      pulse_trig(8'h20, 3);
      repeat (2) @(negedge clk);
      chk(permit_ok == 1'b1, "R9 short gap", 64'(permit_ok), 64'd1);
      @(posedge clk) ref_man = 1'b1;
      @(negedge clk) rise_cyc = cyc;
      repeat (130) @(negedge clk);
      chk(nfr == base + 1, "R8 count", 64'(nfr - base), 64'd1);
      chk(fr_cyc[base] - rise_cyc == 4, "R8 alignment", 64'(fr_cyc[base] - rise_cyc), 64'd4);
      chk_frame(base, 16'h0204, stamp, "R8 code");
      ref_man = 1'b0; ref_run = 1'b1;
      repeat (20) @(negedge clk);
    end

    // R9 fault and R10 behaviour under fault
    ref_run = 1'b0;
    repeat (40) @(negedge clk);
    chk(permit_ok == 1'b0, "R9 fault", 64'(permit_ok), 64'd0);
    base = nfr;
    pulse_trig(8'h05, 3);
    repeat (300) @(negedge clk);
    chk(nfr == base + 1, "R10 only fall", 64'(nfr - base), 64'd1);
    chk_frame(base, 16'h0211, stamp, "R10 fall code");
    ref_run = 1'b1;
    repeat (30) @(negedge clk);
    chk(permit_ok == 1'b0, "R9 latched", 64'(permit_ok), 64'd0);
    chk(nfr == base + 1, "R10 held", 64'(nfr - base), 64'd1);
    @(negedge clk) fault_clr = 1'b1;
    @(negedge clk) fault_clr = 1'b0;
    repeat (3) @(negedge clk);
    chk(permit_ok == 1'b1, "R9 cleared", 64'(permit_ok), 64'd1);
    repeat (150) @(negedge clk);
    chk(nfr == base + 2, "R10 release", 64'(nfr - base), 64'd2);
    chk_frame(base + 1, 16'h0201, stamp, "R10 held code");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule